// File: doc/BRIEF.md
# Stereo DAC Attenuation and Mute Stage

This block sits in the sample path between a stereo audio source and a digital-to-analog converter. Each accepted pair of signed 24-bit PCM samples is scaled by a per-channel attenuation, then forced to zero when that channel is muted. A channel can be muted by its own control bit or by an automatic detector that watches for long runs of static data. Gain codes are in half-decibel units. They can take effect at once or be held back until the waveform crosses zero, so that a gain step does not cause an audible click.

The right channel takes its gain from the A code and the left channel takes its gain from the B code. Every accepted sample produces one output sample one clock later. The mute status flags report, per channel, whether output is currently forced to zero.

Top module: `dac_vol_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `out_valid`, both output samples and both muted flags are 0.
- R2: A sample accepted with `in_valid` high in cycle N appears on the outputs with `out_valid` high in cycle N+1. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R3: With code c (unsigned 8 bits, 0.5 dB per LSB), let n = c/12 and f = c mod 12. Let G be the table 65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792, indexed by f. The output is floor(s*G[f] / 2^(16+n)), where s is the signed input. Code 0 passes the sample unchanged.
- R4: Codes above 254 (-127 dB) behave exactly like code 254.
- R5: The right output is scaled by `atten_a` and the left output by `atten_b`, independently.
- R6: While a channel's manual mute bit is 1, that channel's output sample is exactly 0 and its muted flag is 1. The other channel is unaffected.
- R7: With `auto_mute_en` = 1, a channel's output becomes 0 and its muted flag goes high on the 8192nd consecutive static input sample of that channel. A static sample is 0x000000 or 0xFFFFFF. The 8191st static sample still passes normally.
- R8: After an auto-mute, the first non-static sample of that channel passes normally and clears the channel's muted flag.
- R9: With `auto_mute_en` = 0, static runs of any length never mute the output.
- R10: With `zero_cross_en` = 1, a changed gain code is adopted only on a sample whose sign bit (bit 23) differs from that of the channel's previous sample, and it is already applied to that sample. Otherwise the last adopted code stays in use. With `zero_cross_en` = 0, the current code applies to every sample.
- R11: Each muted flag is registered every clock as manual mute OR (`auto_mute_en` AND auto-mute state). It therefore follows a manual mute change one cycle later, even without samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| atten_a | input | 8 | Right channel attenuation code, 0.5 dB per LSB |
| atten_b | input | 8 | Left channel attenuation code, 0.5 dB per LSB |
| mute_left | input | 1 | Manual mute, left |
| mute_right | input | 1 | Manual mute, right |
| auto_mute_en | input | 1 | Enables muting on static runs |
| zero_cross_en | input | 1 | Defers gain changes to a sign change |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |
| muted_left | output | 1 | Left channel muted status |
| muted_right | output | 1 | Right channel muted status |

## Verification
The hardest behaviour to reach is the auto-mute edge. The output has to stay live through 8191 static samples and go to zero exactly on the 8192nd. The stimulus streams an unbroken run of 0xFFFFFF samples, checks the run's last live sample and then the first muted one, and ends the run with a single non-static sample to test release. A value of -1 is used because, at 0 dB, the muted output (0) differs from the live output (-1), so the muted sample is visible at the ports. Zero-cross deferral is reached by changing the code between two same-sign samples and then sending one of the opposite sign.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

    // Fractional gain in Q16 for f half-dB steps inside one 6 dB octave
    function automatic logic [16:0] frac_gain(input logic [3:0] f);
        logic [16:0] g;
        case (f)
            4'd0:    g = 17'd65536;
            4'd1:    g = 17'd61870;
            4'd2:    g = 17'd58409;
            4'd3:    g = 17'd55142;
            4'd4:    g = 17'd52057;
            4'd5:    g = 17'd49145;
            4'd6:    g = 17'd46396;
            4'd7:    g = 17'd43801;
            4'd8:    g = 17'd41350;
            4'd9:    g = 17'd39037;
            4'd10:   g = 17'd36854;
            4'd11:   g = 17'd34792;
            default: g = 17'd65536;
        endcase
        return g;
    endfunction

    typedef struct packed {
        logic valid;
    } top_state_t;

endpackage

// File: rtl/dvs_atten.sv
module dvs_atten #(
    parameter int W        = 24,
    parameter int CODE_W   = 8,
    parameter int MAX_CODE = 254
) (
    input  logic [W-1:0]      sample,
    input  logic [CODE_W-1:0] code,
    output logic [W-1:0]      result
);
    import dvs_pkg::*;

    localparam int GAIN_FRAC = 16;
    localparam logic [CODE_W-1:0] MAX_C  = CODE_W'(MAX_CODE);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(12);

    logic [CODE_W-1:0]   code_sat;
    logic [CODE_W-1:0]   octave;
    logic [3:0]          frac;
    logic [16:0]         gain;
    logic [CODE_W:0]     sh_amt;
    logic signed [W+17:0] prod;
    logic signed [W+17:0] scaled;

    always_comb begin
        code_sat = (code > MAX_C) ? MAX_C : code;
        octave   = code_sat / STEP_C;
        frac     = 4'(code_sat % STEP_C);
        gain     = frac_gain(frac);
        sh_amt   = (CODE_W+1)'(GAIN_FRAC) + {1'b0, octave};
        prod     = $signed(sample) * $signed({1'b0, gain});
        scaled   = prod >>> sh_amt;
        result   = scaled[W-1:0];
    end

endmodule

// File: rtl/dvs_channel.sv
module dvs_channel #(
    parameter int W        = 24,
    parameter int CODE_W   = 8,
    parameter int MAX_CODE = 254,
    parameter int AM_LEN   = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      sample,
    input  logic [CODE_W-1:0] code,
    input  logic              manual_mute,
    input  logic              am_en,
    input  logic              zc_en,
    output logic [W-1:0]      sample_o,
    output logic              muted_o
);
    localparam int CNT_W = $clog2(AM_LEN + 1);
    localparam logic [CNT_W-1:0] AM_LIM = CNT_W'(AM_LEN);

    typedef struct packed {
        logic [CODE_W-1:0] act_code;
        logic              prev_neg;
        logic [CNT_W-1:0]  cnt;
        logic              am;
        logic [W-1:0]      out;
        logic              muted;
    } ch_state_t;

    ch_state_t q, d;
    logic [CODE_W-1:0] eff_code;
    logic [W-1:0]      att;

    // gain code in force for the incoming sample
    always_comb begin
        eff_code = q.act_code;
        if (!zc_en || (sample[W-1] != q.prev_neg)) begin
            eff_code = code;
        end
    end

    dvs_atten #(
        .W(W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
    ) u_att (
        .sample(sample),
        .code  (eff_code),
        .result(att)
    );

    always_comb begin
        logic is_static;
        logic am_cur;
        d         = q;
        is_static = (sample == '0) || (sample == '1);
        am_cur    = q.am;
        if (in_valid) begin
            d.act_code = eff_code;
            d.prev_neg = sample[W-1];
            if (is_static) begin
                d.cnt = (q.cnt == AM_LIM) ? AM_LIM : q.cnt + 1'b1;
            end else begin
                d.cnt = '0;
            end
            d.am   = (d.cnt == AM_LIM);
            am_cur = d.am;
            d.out  = (manual_mute || (am_en && am_cur)) ? '0 : att;
        end
        d.muted = manual_mute || (am_en && am_cur);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sample_o = q.out;
    assign muted_o  = q.muted;

endmodule

// File: rtl/dac_vol_stage.sv
module dac_vol_stage #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 8,
    parameter int MAX_CODE = 254,
    parameter int AM_LEN   = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]   atten_a,
    input  logic [CODE_W-1:0]   atten_b,
    input  logic                mute_left,
    input  logic                mute_right,
    input  logic                auto_mute_en,
    input  logic                zero_cross_en,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                muted_left,
    output logic                muted_right
);
    import dvs_pkg::*;

    localparam int NCH = 2;

    logic [SAMPLE_W-1:0] ch_in   [NCH];
    logic [CODE_W-1:0]   ch_code [NCH];
    logic                ch_mute [NCH];
    logic [SAMPLE_W-1:0] ch_out  [NCH];
    logic                ch_mtd  [NCH];

    // index 0 = left (B code), index 1 = right (A code)
    assign ch_in[0]   = in_left;
    assign ch_in[1]   = in_right;
    assign ch_code[0] = atten_b;
    assign ch_code[1] = atten_a;
    assign ch_mute[0] = mute_left;
    assign ch_mute[1] = mute_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dvs_channel #(
            .W(SAMPLE_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .AM_LEN(AM_LEN)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid),
            .sample     (ch_in[c]),
            .code       (ch_code[c]),
            .manual_mute(ch_mute[c]),
            .am_en      (auto_mute_en),
            .zc_en      (zero_cross_en),
            .sample_o   (ch_out[c]),
            .muted_o    (ch_mtd[c])
        );
    end

    top_state_t q, d;

    always_comb begin
        d       = q;
        d.valid = in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.valid;
    assign out_left    = ch_out[0];
    assign out_right   = ch_out[1];
    assign muted_left  = ch_mtd[0];
    assign muted_right = ch_mtd[1];

endmodule

// File: rtl/dvs_checker.sv
module dvs_checker #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic [CODE_W-1:0]   atten_a,
    input logic [CODE_W-1:0]   atten_b,
    input logic                mute_left,
    input logic                mute_right,
    input logic                auto_mute_en,
    input logic                zero_cross_en,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic                muted_left,
    input logic                muted_right
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid)));

    p_mute_zero_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && muted_left) |-> (out_left == '0));

    p_mute_zero_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && muted_right) |-> (out_right == '0));

    p_manual_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mute_left) && $past(mute_right)) |-> (muted_left && muted_right));

    p_no_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!auto_mute_en) && $past(!mute_left)) |-> !muted_left);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && $past(!mute_left)
         && $past(in_left != '0 && in_left != '1)) |-> !muted_left);

endmodule

bind dac_vol_stage dvs_checker #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_dac_vol_stage.sv
`timescale 1ns/1ps
module sim_dac_vol_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [7:0]  atten_a = '0, atten_b = '0;
    logic        mute_left = 1'b0, mute_right = 1'b0;
    logic        auto_mute_en = 1'b0, zero_cross_en = 1'b0;
    logic        out_valid;
    logic [23:0] out_left, out_right;
    logic        muted_left, muted_right;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dac_vol_stage u0 (.*);

    localparam int GT [12] = '{65536, 61870, 58409, 55142, 52057, 49145,
                               46396, 43801, 41350, 39037, 36854, 34792};

    // {left, right, code_a, code_b}
    localparam int NV = 7;
    localparam logic [63:0] VEC [NV] = '{
        {24'h100000, 24'h100000, 8'd0,   8'd0},
        {24'h7FFFFF, 24'h800000, 8'd12,  8'd1},
        {24'h123456, 24'hFEDCBA, 8'd5,   8'd30},
        {24'h400001, 24'h800001, 8'd254, 8'd200},
        {24'h765432, 24'h89ABCD, 8'd255, 8'd253},
        {24'hFFFF00, 24'h000100, 8'd11,  8'd23},
        {24'h654321, 24'h9ABCDE, 8'd200, 8'd255}
    };

    function automatic logic [23:0] ref_att(logic [23:0] s, logic [7:0] c);
        int cc;
        longint p;
        cc = (c > 8'd254) ? 254 : int'(c);
        p  = longint'($signed(s)) * longint'(GT[cc % 12]);
        p  = p >>> (16 + cc / 12);
        return p[23:0];
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [23:0] l, logic [23:0] r, logic v);
        in_left  = l;
        in_right = r;
        in_valid = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 valid", {23'd0, out_valid}, 24'd0);
        chk("R1 left", out_left, 24'd0);
        chk("R1 flags", {22'd0, muted_left, muted_right}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 right after", out_right, 24'd0);

        // R3 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            atten_a = v[15:8];
            atten_b = v[7:0];
            step(v[63:40], v[39:16], 1'b1);
            chk("R3/R5 left",  out_left,  ref_att(v[63:40], v[7:0]));
            chk("R3/R5 right", out_right, ref_att(v[39:16], v[15:8]));
            chk("R2 valid", {23'd0, out_valid}, 24'd1);
        end
        // R4 explicit: 255 equals 254
        chk("R4 sat", ref_att(24'h765432, 8'd255), ref_att(24'h765432, 8'd254));
        atten_a = 8'd255;
        atten_b = 8'd254;
        step(24'h765432, 24'h765432, 1'b1);
        chk("R4 sat ports", out_right, out_left);

        // R2 idle
        step(24'h111111, 24'h111111, 1'b0);
        chk("R2 idle valid", {23'd0, out_valid}, 24'd0);

        // R6 manual mute left only
        atten_a = 8'd0;
        atten_b = 8'd0;
        mute_left = 1'b1;
        step(24'h123456, 24'h234567, 1'b1);
        chk("R6 left zero", out_left, 24'd0);
        chk("R6 left flag", {23'd0, muted_left}, 24'd1);
        chk("R6 right live", out_right, 24'h234567);
        chk("R6 right flag", {23'd0, muted_right}, 24'd0);
        mute_left = 1'b0;

        // R11 flag follows manual mute without samples
        mute_right = 1'b1;
        step(24'h0, 24'h0, 1'b0);
        chk("R11 flag on", {23'd0, muted_right}, 24'd1);
        mute_right = 1'b0;
        step(24'h0, 24'h0, 1'b0);
        chk("R11 flag off", {23'd0, muted_right}, 24'd0);

        // R7 auto-mute after 8192 static samples
        step(24'h000123, 24'h000123, 1'b1);
        auto_mute_en = 1'b1;
        for (int i = 0; i < 8191; i++) step(24'hFFFFFF, 24'hFFFFFF, 1'b1);
        chk("R7 8191st live", out_left, 24'hFFFFFF);
        chk("R7 8191st flag", {23'd0, muted_left}, 24'd0);
        step(24'hFFFFFF, 24'hFFFFFF, 1'b1);
        chk("R7 8192nd left", out_left, 24'd0);
        chk("R7 8192nd right", out_right, 24'd0);
        chk("R7 flag", {22'd0, muted_left, muted_right}, 24'd3);
        step(24'h000000, 24'h000000, 1'b1);
        chk("R7 held", {23'd0, muted_left}, 24'd1);
        // R8 release
        step(24'h000005, 24'hFFFFFE, 1'b1);
        chk("R8 left", out_left, 24'h000005);
        chk("R8 right", out_right, 24'hFFFFFE);
        chk("R8 flag", {22'd0, muted_left, muted_right}, 24'd0);

        // R9 disabled auto-mute
        auto_mute_en = 1'b0;
        for (int i = 0; i < 8200; i++) step(24'hFFFFFF, 24'hFFFFFF, 1'b1);
        chk("R9 live", out_left, 24'hFFFFFF);
        chk("R9 flag", {23'd0, muted_left}, 24'd0);

        // R10 zero-cross deferral (previous sample negative)
        zero_cross_en = 1'b1;
        atten_a = 8'd0;
        atten_b = 8'd0;
        step(24'h100000, 24'h100000, 1'b1);
        chk("R10 adopt 0", out_left, 24'h100000);
        atten_a = 8'd12;
        atten_b = 8'd12;
        step(24'h100000, 24'h100000, 1'b1);
        chk("R10 held", out_left, 24'h100000);
        step(24'hF00000, 24'hF00000, 1'b1);
        chk("R10 cross", out_right, 24'hF80000);
        step(24'h100000, 24'h100000, 1'b1);
        chk("R10 kept", out_left, 24'h080000);
        zero_cross_en = 1'b0;
        atten_b = 8'd24;
        step(24'h100000, 24'h100000, 1'b1);
        chk("R10 immediate", out_left, 24'h040000);
        step(24'h0, 24'h0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule